// File: doc/BRIEF.md
# Max-Shifted Softmax Attention Weighting Unit

This block takes the attention scores of one query, each paired with a row of values. It turns the scores into softmax weights and returns the weighted average of the value rows. Scores arrive as a stream of signed fixed-point numbers. Each beat carries one score and its whole value row. The block stores every beat in a small buffer and tracks the largest score as the beats arrive. The first pass ends at the beat flagged as last.

A second pass then reads the buffer back. For each entry it forms the distance from the maximum, which is never negative. The weight is the exponential of minus that distance. It is found by splitting the distance into a coarse part and a fine part, reading two small tables and multiplying the two entries. The weights are summed, and each weight times its value row is summed into one accumulator per lane.

At the end of the pass the accumulators and the weight sum go to a serial divide stage. That stage runs while the next query is being loaded and weighted, and it emits the result vector as a single-cycle pulse.

Top module: `attn_softmax_unit`

## Requirements
- R1: Scores are signed Q8.8 (8 fractional bits). The unit keeps the running maximum of the current query, so adding the same constant to every score of a query leaves the result vector bit-identical.
- R2: Each weight is exp(-(max - score)) in unsigned Q1.15, so the maximal score gets exactly 32768 (1.0). A query of one beat therefore returns its value row unchanged.
- R3: A distance of d LSBs (d below 2048) is split into a coarse index d[10:4] and a fine index d[3:0]. The weight is the rounded product of exp(-coarse*16/256) and exp(-fine/256), each held in Q1.15.
- R4: A distance of 2048 LSBs (8.0) or more gives a weight of exactly 0. A distance of 2047 still gives a nonzero weight.
- R5: Each output lane j is sum(w_i * v_ij) / sum(w_i), truncated toward zero, and lies within 2 of the real-valued result of R1 to R4. Value lane j sits in bits [16j+15:16j] of the value and output ports, and both are signed 16-bit.
- R6: in_ready is high while a query is being loaded. It is low in the cycle after the last beat is accepted, until that query has been handed to the divide stage.
- R7: A query holds at most 8 beats. The 8th accepted beat ends the query even when in_last is low.
- R8: Results leave in query order, one out_valid pulse of one cycle per query. Loading the next query may start while the previous one is still in the divide stage.
- R9: After reset, in_ready is 1, out_valid is 0 and out_vec is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Score beat valid |
| in_ready | output | 1 | Unit accepts a beat this cycle |
| in_score | input | 16 | Signed Q8.8 attention score |
| in_value | input | 64 | Value row, four signed 16-bit lanes |
| in_last | input | 1 | Beat is the final one of its query |
| out_valid | output | 1 | One-cycle pulse, out_vec holds a result |
| out_vec | output | 64 | Result row, four signed 16-bit lanes |

## Verification
Six queries of differing length are streamed back to back. They cover a wide positive and negative spread, all-equal scores (a plain average), scores packed near the most negative code, and a pair whose distance passes the table range. Together they compare every lane against a real-valued softmax model and show that a finished query is divided while the next loads. Directed queries single out the rest. A one-beat query must be returned exactly. A query and its copy shifted by 5.0 must match bit for bit, which shows the maximum is subtracted. Distances of 2048 and 2047 fall on either side of the zero cut-off. An eight-beat query without a last flag must still close.

// File: rtl/attn_sm_pkg.sv
package attn_sm_pkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_RUN  = 2'd1,
    ST_HAND = 2'd2
  } attn_phase_t;

  // exp(-n * 2^-shift) as an unsigned fixed-point value with frac bits.
  // The base is built by a Taylor series in Q30 and then raised to n.
  function automatic longint exp_q(input int shift, input int n, input int frac);
    longint one;
    longint term;
    longint base;
    longint r;
    one  = 64'sd1 <<< 30;
    term = one;
    base = one;
    r    = one;
    for (int k = 1; k < 12; k++) begin
      term = -((term >>> shift) / longint'(k));
      base = base + term;
    end
    for (int i = 0; i < n; i++) begin
      r = (r * base) >>> 30;
    end
    return (r + (64'sd1 <<< (29 - frac))) >>> (30 - frac);
  endfunction

endpackage

// File: rtl/attn_row_buf.sv
module attn_row_buf #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/attn_exp_split.sv
module attn_exp_split #(
  parameter int DIFF_W = 17,
  parameter int FRAC_W = 8,
  parameter int LO_W   = 4,
  parameter int HI_W   = 7,
  parameter int EXP_W  = 16,
  parameter int TAG_W  = 65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DIFF_W-1:0] in_diff,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [EXP_W-1:0]  out_exp,
  output logic [TAG_W-1:0]  out_tag
);
  localparam int RANGE_B = LO_W + HI_W;
  localparam int HI_N    = 1 << HI_W;
  localparam int LO_N    = 1 << LO_W;
  localparam int EFRAC   = EXP_W - 1;
  localparam logic [EXP_W-1:0] ONE = EXP_W'(1) << EFRAC;

  logic [EXP_W-1:0] hi_rom [HI_N];
  logic [EXP_W-1:0] lo_rom [LO_N];

  // coarse table: exp(-h * 2^LO_W / 2^FRAC_W)
  for (genvar g = 0; g < HI_N; g++) begin : g_hi
    localparam logic [EXP_W-1:0] HV = EXP_W'(attn_sm_pkg::exp_q(FRAC_W - LO_W, g, EFRAC));
    assign hi_rom[g] = HV;
  end
  // fine table: exp(-l / 2^FRAC_W)
  for (genvar g = 0; g < LO_N; g++) begin : g_lo
    localparam logic [EXP_W-1:0] LV = EXP_W'(attn_sm_pkg::exp_q(FRAC_W, g, EFRAC));
    assign lo_rom[g] = LV;
  end

  logic far;
  assign far = |in_diff[DIFF_W-1:RANGE_B];

  logic             s1_valid, s1_zero;
  logic [EXP_W-1:0] s1_hi, s1_lo;
  logic [TAG_W-1:0] s1_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
    s1_zero <= far;
    s1_hi   <= hi_rom[in_diff[RANGE_B-1:LO_W]];
    s1_lo   <= lo_rom[in_diff[LO_W-1:0]];
    s1_tag  <= in_tag;
  end

  logic [2*EXP_W-1:0] prod;
  always_comb begin
    prod = s1_hi * s1_lo + ((2*EXP_W)'(1) << (EFRAC - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s1_valid;
    end
    out_exp <= s1_zero ? '0 : prod[EFRAC +: EXP_W];
    out_tag <= s1_tag;
  end

  // R4: a distance past the table range yields a zero weight two cycles later
  a_r4_far_is_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && far) |=> ##1 (out_valid && out_exp == '0));

  // R2: no weight ever exceeds 1.0
  a_r2_exp_le_one: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_exp <= ONE));
endmodule

// File: rtl/attn_div_array.sv
module attn_div_array #(
  parameter int LANES = 4,
  parameter int NUM_W = 36,
  parameter int DEN_W = 19,
  parameter int OUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [LANES*NUM_W-1:0] num_flat,
  input  logic [DEN_W-1:0]       den,
  output logic                   busy,
  output logic                   out_valid,
  output logic [LANES*OUT_W-1:0] out_flat
);
  localparam int ITW = $clog2(NUM_W);

  logic             busy_q, run_q, fin_q;
  logic [ITW-1:0]   iter_q;
  logic [DEN_W-1:0] den_q;

  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      run_q     <= 1'b0;
      fin_q     <= 1'b0;
      iter_q    <= '0;
      out_valid <= 1'b0;
      den_q     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        run_q  <= 1'b1;
        iter_q <= '0;
        den_q  <= den;
      end else if (run_q) begin
        iter_q <= iter_q + 1'b1;
        if (iter_q == ITW'(NUM_W - 1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end else if (fin_q) begin
        fin_q     <= 1'b0;
        busy_q    <= 1'b0;
        out_valid <= 1'b1;
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic signed [NUM_W-1:0] num_l;
    logic [NUM_W-1:0]        mag_q, quo_q;
    logic [DEN_W-1:0]        rem_q;
    logic                    neg_q;
    logic [OUT_W-1:0]        res_q;
    logic [DEN_W:0]          rem_sh;
    logic                    take;

    assign num_l = num_flat[j*NUM_W +: NUM_W];

    always_comb begin
      rem_sh = {rem_q, mag_q[NUM_W-1]};
      take   = rem_sh >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        res_q <= '0;
        mag_q <= '0;
        quo_q <= '0;
        rem_q <= '0;
        neg_q <= 1'b0;
      end else if (start) begin
        neg_q <= num_l[NUM_W-1];
        mag_q <= num_l[NUM_W-1] ? NUM_W'(-num_l) : NUM_W'(num_l);
        rem_q <= '0;
        quo_q <= '0;
      end else if (run_q) begin
        rem_q <= take ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
        mag_q <= mag_q << 1;
        quo_q <= {quo_q[NUM_W-2:0], take};
      end else if (fin_q) begin
        res_q <= neg_q ? OUT_W'(-quo_q) : OUT_W'(quo_q);
      end
    end

    assign out_flat[j*OUT_W +: OUT_W] = res_q;
  end

  // R8: each result is announced by a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: a new query is never handed over while one is in flight
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);

  // R5: the weight sum handed over is never zero
  a_r5_den_nonzero: assert property (@(posedge clk) disable iff (rst)
    start |-> (den != '0));
endmodule

// File: rtl/attn_softmax_unit.sv
module attn_softmax_unit #(
  parameter int N_MAX  = 8,
  parameter int D      = 4,
  parameter int SW     = 16,
  parameter int FRAC_W = 8,
  parameter int LO_W   = 4,
  parameter int HI_W   = 7,
  parameter int VAL_W  = 16,
  parameter int EXP_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_score,
  input  logic [D*VAL_W-1:0]   in_value,
  input  logic                 in_last,
  output logic                 out_valid,
  output logic [D*VAL_W-1:0]   out_vec
);
  import attn_sm_pkg::*;

  localparam int AW     = $clog2(N_MAX);
  localparam int ROW_W  = D * VAL_W;
  localparam int BUF_W  = SW + ROW_W;
  localparam int DIFF_W = SW + 1;
  localparam int SUM_W  = EXP_W + AW;
  localparam int ACC_W  = EXP_W + 1 + VAL_W + AW;
  localparam int TAG_W  = ROW_W + 1;

  attn_phase_t          state_q;
  logic [AW-1:0]        cnt_q, last_q, rd_ptr_q;
  logic signed [SW-1:0] max_q;
  logic                 iss_q, v1_q, l1_q;
  logic                 in_fire, q_end, div_start, div_busy;
  logic [BUF_W-1:0]     rd_data;

  assign in_ready  = (state_q == ST_LOAD);
  assign in_fire   = in_valid && in_ready;
  assign q_end     = in_last || (cnt_q == AW'(N_MAX - 1));
  assign div_start = (state_q == ST_HAND) && !div_busy;

  logic             term_valid, term_last;
  logic [EXP_W-1:0] term_exp;
  logic [TAG_W-1:0] term_tag;
  logic [ROW_W-1:0] term_row;
  assign term_last = term_tag[ROW_W];
  assign term_row  = term_tag[ROW_W-1:0];

  // ---- control: load pass, read-back pass, hand-off ----
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_LOAD;
      cnt_q    <= '0;
      last_q   <= '0;
      rd_ptr_q <= '0;
      max_q    <= '0;
      iss_q    <= 1'b0;
      v1_q     <= 1'b0;
      l1_q     <= 1'b0;
    end else begin
      v1_q <= iss_q;
      l1_q <= iss_q && (rd_ptr_q == last_q);
      case (state_q)
        ST_LOAD: begin
          if (in_fire) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0 || in_score > max_q) max_q <= in_score;
            if (q_end) begin
              state_q  <= ST_RUN;
              last_q   <= cnt_q;
              rd_ptr_q <= '0;
              iss_q    <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (iss_q) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
            if (rd_ptr_q == last_q) iss_q <= 1'b0;
          end
          if (term_valid && term_last) state_q <= ST_HAND;
        end
        ST_HAND: begin
          if (!div_busy) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  attn_row_buf #(.DEPTH(N_MAX), .WIDTH(BUF_W)) u_buf (
    .clk   (clk),
    .we    (in_fire),
    .waddr (cnt_q),
    .wdata ({in_score, in_value}),
    .re    (iss_q),
    .raddr (rd_ptr_q),
    .rdata (rd_data)
  );

  logic signed [SW-1:0]     rd_score;
  logic signed [DIFF_W-1:0] diff_s;
  assign rd_score = rd_data[BUF_W-1 -: SW];
  assign diff_s   = DIFF_W'(max_q) - DIFF_W'(rd_score);

  attn_exp_split #(
    .DIFF_W (DIFF_W), .FRAC_W (FRAC_W), .LO_W (LO_W), .HI_W (HI_W),
    .EXP_W  (EXP_W),  .TAG_W  (TAG_W)
  ) u_exp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (v1_q),
    .in_diff   (diff_s),
    .in_tag    ({l1_q, rd_data[ROW_W-1:0]}),
    .out_valid (term_valid),
    .out_exp   (term_exp),
    .out_tag   (term_tag)
  );

  // ---- accumulation of weight sum and weighted value rows ----
  logic [SUM_W-1:0]     sum_q;
  logic [D*ACC_W-1:0]   acc_flat;

  always_ff @(posedge clk) begin
    if (rst || div_start) sum_q <= '0;
    else if (term_valid)  sum_q <= sum_q + SUM_W'(term_exp);
  end

  for (genvar j = 0; j < D; j++) begin : g_acc
    logic signed [ACC_W-1:0] acc_q, prod;
    always_comb begin
      prod = ACC_W'($signed({1'b0, term_exp}) * $signed(term_row[j*VAL_W +: VAL_W]));
    end
    always_ff @(posedge clk) begin
      if (rst || div_start) acc_q <= '0;
      else if (term_valid)  acc_q <= acc_q + prod;
    end
    assign acc_flat[j*ACC_W +: ACC_W] = acc_q;
  end

  attn_div_array #(.LANES(D), .NUM_W(ACC_W), .DEN_W(SUM_W), .OUT_W(VAL_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .start     (div_start),
    .num_flat  (acc_flat),
    .den       (sum_q),
    .busy      (div_busy),
    .out_valid (out_valid),
    .out_flat  (out_vec)
  );

  // R1: the tracked maximum never falls below an accepted score of the query
  a_r1_max_dominates: assert property (@(posedge clk) disable iff (rst)
    (in_fire && cnt_q != '0) |=> ($signed(max_q) >= $signed($past(in_score))));

  // R2: every buffered score lies at or below the tracked maximum
  a_r2_diff_nonneg: assert property (@(posedge clk) disable iff (rst)
    v1_q |-> !diff_s[DIFF_W-1]);

  // R6: the beat carrying the last flag closes the input
  a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_fire && in_last) |=> !in_ready);

  // R7: the beat that fills the buffer starts the read-back pass
  a_r7_depth_cap: assert property (@(posedge clk) disable iff (rst)
    (in_fire && cnt_q == AW'(N_MAX - 1)) |=> (state_q == ST_RUN));

  // R5: a nonzero weight strictly grows the weight sum
  a_r5_sum_grows: assert property (@(posedge clk) disable iff (rst)
    (term_valid && term_exp != '0 && !div_start) |=> (sum_q > $past(sum_q)));
endmodule

// File: tb/attn_softmax_unit_tb.sv
`timescale 1ns/1ps
module attn_softmax_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic signed [15:0] in_score = '0;
  logic [63:0] in_value = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic [63:0] out_vec;

  always #4 clk = ~clk;

  attn_softmax_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_score(in_score), .in_value(in_value), .in_last(in_last),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int n_sent   = 0;
  int n_got    = 0;
  bit done     = 1'b0;

  real   exp_y  [64][4];
  string req_of [64];
  int    got    [64][4];

  logic signed [15:0] q_sc [8];
  int                 q_v  [8][4];

  // Stimulus table (scores in Q8.8); value rows come from the seed.
  localparam int NT = 6;
  localparam int T_LEN  [NT] = '{4, 8, 3, 5, 2, 6};
  localparam int T_SEED [NT] = '{1, 2, 3, 4, 5, 6};
  localparam logic signed [15:0] T_SC [NT][8] = '{
    '{16'sd256,    -16'sd128,   16'sd512,    16'sd0,      16'sd0,     16'sd0,    16'sd0,   16'sd0},
    '{-16'sd1000,  16'sd1500,   16'sd300,    -16'sd200,   16'sd700,   16'sd1400, -16'sd50, 16'sd0},
    '{16'sd100,    16'sd100,    16'sd100,    16'sd0,      16'sd0,     16'sd0,    16'sd0,   16'sd0},
    '{-16'sd30000, -16'sd29500, -16'sd31000, -16'sd30200, -16'sd29900, 16'sd0,   16'sd0,   16'sd0},
    '{16'sd2000,   -16'sd2000,  16'sd0,      16'sd0,      16'sd0,     16'sd0,    16'sd0,   16'sd0},
    '{16'sd600,    16'sd640,    16'sd590,    16'sd100,    -16'sd400,  16'sd620,  16'sd0,   16'sd0}
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic fill_vals(input int seed);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 4; j++)
        q_v[i][j] = (((i * 37 + j * 91 + seed * 53) % 401) - 200) * 7;
  endtask

  // Real-valued model of R1..R5
  task automatic model(input int len, input string req);
    real w [8];
    real s;
    int  mx;
    mx = q_sc[0];
    for (int i = 1; i < len; i++) if (q_sc[i] > mx) mx = q_sc[i];
    s = 0.0;
    for (int i = 0; i < len; i++) begin
      int d = mx - q_sc[i];
      w[i] = (d >= 2048) ? 0.0 : $exp(-real'(d) / 256.0);
      s += w[i];
    end
    for (int j = 0; j < 4; j++) begin
      real a = 0.0;
      for (int i = 0; i < len; i++) a += w[i] * real'(q_v[i][j]);
      exp_y[n_sent][j] = a / s;
    end
    req_of[n_sent] = req;
    n_sent++;
  endtask

  // Drives one query; call at a negedge. drop_last keeps in_last low.
  task automatic send_query(input int len, input bit drop_last, input string req);
    model(len, req);
    for (int i = 0; i < len; i++) begin
      while (!in_ready) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_score = q_sc[i];
      for (int j = 0; j < 4; j++) in_value[j*16 +: 16] = 16'(q_v[i][j]);
      in_last  = (i == len - 1) && !drop_last;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (drop_last) check(in_ready == 1'b0, "R7", "ready after 8th beat", int'(in_ready), 0);
    else           check(in_ready == 1'b0, "R6", "ready after last beat", int'(in_ready), 0);
  endtask

  task automatic drain();
    int t = 0;
    while (n_got < n_sent && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(n_got == n_sent, "R8", "results received", n_got, n_sent);
  endtask

  // Result collector: compares each result with the model (R5, R3)
  always @(negedge clk) begin
    if (!rst && out_valid && n_got < 64) begin
      bit ok = 1'b1;
      int bad = 0;
      for (int j = 0; j < 4; j++) begin
        real e;
        got[n_got][j] = int'($signed(out_vec[j*16 +: 16]));
        e = exp_y[n_got][j];
        if (real'(got[n_got][j]) > e + 2.0 || real'(got[n_got][j]) < e - 2.0) begin
          ok = 1'b0;
          bad = j;
        end
      end
      n_checks++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s result %0d lane %0d: actual %0d expected %f",
                 req_of[n_got], n_got, bad, got[n_got][bad], exp_y[n_got][bad]);
      end
      n_got++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    bit overlap_seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(in_ready == 1'b1, "R9", "in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R9", "out_valid", int'(out_valid), 0);
    check(out_vec == '0, "R9", "out_vec", int'(out_vec[31:0]), 0);

    // Table walk, queries back to back (R3 R5 R8)
    overlap_seen = 1'b0;
    for (int t = 0; t < NT; t++) begin
      for (int i = 0; i < 8; i++) q_sc[i] = T_SC[t][i];
      fill_vals(T_SEED[t]);
      send_query(T_LEN[t], 1'b0, "R3 R5");
      while (!in_ready) @(negedge clk);
      if (n_got < n_sent) overlap_seen = 1'b1;
    end
    drain();
    check(overlap_seen, "R8", "load overlapped a pending divide", int'(overlap_seen), 1);

    // R2: one beat returns its row exactly
    base = n_sent;
    q_sc[0] = -16'sd12345;
    q_v[0][0] = 1234; q_v[0][1] = -4321; q_v[0][2] = 32767; q_v[0][3] = -32768;
    send_query(1, 1'b0, "R2");
    drain();
    for (int j = 0; j < 4; j++) check(got[base][j] == q_v[0][j], "R2", "single-beat lane", got[base][j], q_v[0][j]);

    // R1: constant offset on all scores gives identical results
    base = n_sent;
    fill_vals(9);
    q_sc[0] = 16'sd300; q_sc[1] = -16'sd100; q_sc[2] = 16'sd50; q_sc[3] = 16'sd0;
    send_query(4, 1'b0, "R1");
    for (int i = 0; i < 4; i++) q_sc[i] = q_sc[i] + 16'sd1280;
    send_query(4, 1'b0, "R1");
    drain();
    for (int j = 0; j < 4; j++) check(got[base][j] == got[base+1][j], "R1", "shifted query lane", got[base+1][j], got[base][j]);

    // R4: distance 2048 gives zero weight, 2047 does not
    base = n_sent;
    for (int j = 0; j < 4; j++) begin q_v[0][j] = 0; q_v[1][j] = 30000; end
    q_sc[0] = 16'sd0; q_sc[1] = -16'sd2048;
    send_query(2, 1'b0, "R4");
    q_sc[1] = -16'sd2047;
    send_query(2, 1'b0, "R4");
    drain();
    for (int j = 0; j < 4; j++) begin
      check(got[base][j] == 0, "R4", "distance 2048 lane", got[base][j], 0);
      check(got[base+1][j] >= 5, "R4", "distance 2047 lane (min 5)", got[base+1][j], 10);
    end

    // R7: eight beats without a last flag close the query; next query separate
    fill_vals(11);
    for (int i = 0; i < 8; i++) q_sc[i] = 16'(i * 90 - 300);
    send_query(8, 1'b1, "R7");
    fill_vals(12);
    q_sc[0] = 16'sd40; q_sc[1] = -16'sd60;
    send_query(2, 1'b0, "R7");
    drain();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule